// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block decides which operating mode a clock-synchronizing digital PLL is in: freerun, locking, locked (synchronized) or holdover. It watches a set of per-reference qualification flags, a pulse that marks a change of active reference, the loop's lock-detect flag and a flag that says a holdover frequency history is available. From these it works out the mode. Software can also take over through a manual select and force a mode directly.

The mode is held in a register and shown as a 2-bit code. A synchronized status bit is high while the loop is locked. On every mode change the block raises a one-cycle pulse for the mode just entered, plus a common change pulse. The frequency ramp and history logic downstream use these pulses. All pins are plain control and status levels or pulses. No data streams pass through the block, so it has no valid/ready handshake.

Leaving the locking state needs the lock-detect flag to stay high for a programmable number of consecutive cycles. A reference switch or a break in lock-detect restarts that count.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: After reset the mode code is 00 (freerun), the synchronized bit is 0 and every event pulse is 0.
- R2: In automatic mode (auto_sel=1), freerun moves to locking (code 01) on the next clock edge when any bit of ref_qual is high.
- R3: Locking moves to locked (code 10) on the clock edge at which lock_det has been sampled high for lock_dwell consecutive cycles. A low cycle of lock_det restarts the count. A lock_dwell of 0 acts as 1.
- R4: In automatic mode, from locking or locked with no ref_qual bit high, the next mode is holdover (code 11) when hist_valid is 1 and freerun (code 00) when hist_valid is 0.
- R5: In automatic mode, holdover moves to locking when any ref_qual bit is high.
- R6: A ref_switch pulse while locked sends the mode back to locking. While locking, it restarts the lock-detect count.
- R7: In automatic mode, lock_det low while locked with a reference still qualified returns the mode to locking.
- R8: In manual mode (auto_sel=0), man_mode 00 forces freerun, 10 forces locked and 11 forces holdover on the next edge, whatever the reference and lock inputs are. Code 01 keeps the current mode.
- R9: sync_o is 1 exactly while the mode code is 10.
- R10: On each mode change, mode_chg and exactly one entry pulse matching the new mode are high for one cycle, in the same cycle the new code first appears. No pulse is raised while the mode is unchanged.
- R11: In automatic mode, holdover is kept while no reference is qualified, even if hist_valid falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_sel | input | 1 | 1 automatic selection, 0 manual |
| man_mode | input | 2 | Software-written mode code used in manual mode |
| ref_qual | input | NUM_REFS | Per-reference qualified flags |
| ref_switch | input | 1 | One-cycle pulse: active reference changed |
| lock_det | input | 1 | Frequency lock detected |
| hist_valid | input | 1 | A holdover history is available |
| lock_dwell | input | DWELL_W | Consecutive lock cycles required to leave locking |
| mode | output | 2 | Current mode code |
| sync_o | output | 1 | High while locked |
| enter_freerun | output | 1 | Pulse on entry to freerun |
| enter_locking | output | 1 | Pulse on entry to locking |
| enter_locked | output | 1 | Pulse on entry to locked |
| enter_holdover | output | 1 | Pulse on entry to holdover |
| mode_chg | output | 1 | Pulse on any mode change |

## Verification
The bench builds the block with NUM_REFS=3 and DWELL_W=4. Three reference flags let it check that each bit on its own, and all of them together, count as an available reference. The narrow dwell field keeps lock windows down to a few cycles. That makes it cheap to check the exact edge where locking ends, a restart caused by a gap in lock_det or by a reference switch, and the zero-dwell case.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;
  typedef enum logic [1:0] {
    MODE_FREERUN  = 2'b00,
    MODE_LOCKING  = 2'b01,
    MODE_LOCKED   = 2'b10,
    MODE_HOLDOVER = 2'b11
  } op_mode_e;
endpackage

// File: rtl/ref_presence.sv
module ref_presence #(
  parameter int NUM_REFS = 4
) (
  input  logic [NUM_REFS-1:0] ref_qual,
  output logic                any_ref
);
  logic [NUM_REFS:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < NUM_REFS; i++) begin : g_or
    assign chain[i+1] = chain[i] | ref_qual[i];
  end
  assign any_ref = chain[NUM_REFS];
endmodule

// File: rtl/lock_dwell_timer.sv
module lock_dwell_timer #(
  parameter int DWELL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic               lock_det,
  input  logic [DWELL_W-1:0] dwell,
  output logic               reached
);
  localparam logic [DWELL_W-1:0] CNT_MAX = {DWELL_W{1'b1}};

  logic [DWELL_W-1:0] cnt_q;
  logic [DWELL_W:0]   eff_dwell;
  logic [DWELL_W:0]   cnt_inc;

  assign eff_dwell = (dwell == '0) ? {{DWELL_W{1'b0}}, 1'b1} : {1'b0, dwell};
  assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
  assign reached   = run && lock_det && !restart && (cnt_inc >= eff_dwell);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (!run || restart || !lock_det) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mode_next.sv
module mode_next
  import dpll_mode_pkg::*;
(
  input  op_mode_e   cur,
  input  logic       auto_sel,
  input  logic [1:0] man_mode,
  input  logic       any_ref,
  input  logic       hist_valid,
  input  logic       ref_switch,
  input  logic       lock_det,
  input  logic       dwell_done,
  output op_mode_e   nxt
);
  op_mode_e lost_mode;
  assign lost_mode = hist_valid ? MODE_HOLDOVER : MODE_FREERUN;

  always_comb begin
    nxt = cur;
    if (!auto_sel) begin
      unique case (man_mode)
        2'b00:   nxt = MODE_FREERUN;
        2'b10:   nxt = MODE_LOCKED;
        2'b11:   nxt = MODE_HOLDOVER;
        default: nxt = cur;
      endcase
    end else begin
      unique case (cur)
        MODE_FREERUN:  if (any_ref) nxt = MODE_LOCKING;
        MODE_LOCKING: begin
          if (!any_ref)        nxt = lost_mode;
          else if (dwell_done) nxt = MODE_LOCKED;
        end
        MODE_LOCKED: begin
          if (!any_ref)                    nxt = lost_mode;
          else if (ref_switch || !lock_det) nxt = MODE_LOCKING;
        end
        MODE_HOLDOVER: if (any_ref) nxt = MODE_LOCKING;
        default:       nxt = MODE_FREERUN;
      endcase
    end
  end
endmodule

// File: rtl/mode_events.sv
module mode_events
  import dpll_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  op_mode_e nxt,
  output op_mode_e cur,
  output logic     sync_o,
  output logic     enter_freerun,
  output logic     enter_locking,
  output logic     enter_locked,
  output logic     enter_holdover,
  output logic     mode_chg
);
  logic changing;
  assign changing = (nxt != cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur            <= MODE_FREERUN;
      sync_o         <= 1'b0;
      enter_freerun  <= 1'b0;
      enter_locking  <= 1'b0;
      enter_locked   <= 1'b0;
      enter_holdover <= 1'b0;
      mode_chg       <= 1'b0;
    end else begin
      cur            <= nxt;
      sync_o         <= (nxt == MODE_LOCKED);
      mode_chg       <= changing;
      enter_freerun  <= changing && (nxt == MODE_FREERUN);
      enter_locking  <= changing && (nxt == MODE_LOCKING);
      enter_locked   <= changing && (nxt == MODE_LOCKED);
      enter_holdover <= changing && (nxt == MODE_HOLDOVER);
    end
  end
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int NUM_REFS = 4,
  parameter int DWELL_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                auto_sel,
  input  logic [1:0]          man_mode,
  input  logic [NUM_REFS-1:0] ref_qual,
  input  logic                ref_switch,
  input  logic                lock_det,
  input  logic                hist_valid,
  input  logic [DWELL_W-1:0]  lock_dwell,
  output logic [1:0]          mode,
  output logic                sync_o,
  output logic                enter_freerun,
  output logic                enter_locking,
  output logic                enter_locked,
  output logic                enter_holdover,
  output logic                mode_chg
);
  logic     any_ref;
  logic     dwell_done;
  op_mode_e cur_mode;
  op_mode_e nxt_mode;

  ref_presence #(.NUM_REFS(NUM_REFS)) u_presence (
    .ref_qual (ref_qual),
    .any_ref  (any_ref)
  );

  lock_dwell_timer #(.DWELL_W(DWELL_W)) u_dwell (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (auto_sel && (cur_mode == MODE_LOCKING)),
    .restart  (ref_switch),
    .lock_det (lock_det),
    .dwell    (lock_dwell),
    .reached  (dwell_done)
  );

  mode_next u_next (
    .cur        (cur_mode),
    .auto_sel   (auto_sel),
    .man_mode   (man_mode),
    .any_ref    (any_ref),
    .hist_valid (hist_valid),
    .ref_switch (ref_switch),
    .lock_det   (lock_det),
    .dwell_done (dwell_done),
    .nxt        (nxt_mode)
  );

  mode_events u_events (
    .clk            (clk),
    .rst_n          (rst_n),
    .nxt            (nxt_mode),
    .cur            (cur_mode),
    .sync_o         (sync_o),
    .enter_freerun  (enter_freerun),
    .enter_locking  (enter_locking),
    .enter_locked   (enter_locked),
    .enter_holdover (enter_holdover),
    .mode_chg       (mode_chg)
  );

  assign mode = cur_mode;
endmodule

// File: rtl/dpll_mode_ctrl_checker.sv
module dpll_mode_ctrl_checker #(
  parameter int NUM_REFS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                auto_sel,
  input logic [1:0]          man_mode,
  input logic [NUM_REFS-1:0] ref_qual,
  input logic                lock_det,
  input logic                hist_valid,
  input logic [1:0]          mode,
  input logic                sync_o,
  input logic                enter_freerun,
  input logic                enter_locking,
  input logic                enter_locked,
  input logic                enter_holdover,
  input logic                mode_chg
);
  AST_SYNC_TRACKS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o == (mode == 2'b10)); // R9

  AST_ONE_ENTRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enter_freerun, enter_locking, enter_locked, enter_holdover})); // R10

  AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_chg |-> $stable(mode)); // R10

  AST_PULSE_WITH_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_freerun | enter_locking | enter_locked | enter_holdover) == mode_chg); // R10

  AST_FREERUN_ACQUIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_sel && mode == 2'b00 && (|ref_qual)) |=> (mode == 2'b01)); // R2

  AST_LOSS_TO_HOLDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_sel && (mode == 2'b01 || mode == 2'b10) && !(|ref_qual) && hist_valid)
      |=> (mode == 2'b11)); // R4

  AST_MANUAL_HOLDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_sel && man_mode == 2'b11) |=> (mode == 2'b11)); // R8

  AST_LOCK_NEEDS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_sel && mode == 2'b01 && !lock_det) |=> (mode != 2'b10)); // R3
endmodule

bind dpll_mode_ctrl dpll_mode_ctrl_checker #(.NUM_REFS(NUM_REFS)) u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .auto_sel       (auto_sel),
  .man_mode       (man_mode),
  .ref_qual       (ref_qual),
  .lock_det       (lock_det),
  .hist_valid     (hist_valid),
  .mode           (mode),
  .sync_o         (sync_o),
  .enter_freerun  (enter_freerun),
  .enter_locking  (enter_locking),
  .enter_locked   (enter_locked),
  .enter_holdover (enter_holdover),
  .mode_chg       (mode_chg)
);

// File: tb/dpll_mode_ctrl_test.sv
module dpll_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREF = 3;
  localparam int DW   = 4;

  localparam logic [1:0] FR = 2'b00, LKG = 2'b01, LKD = 2'b10, HO = 2'b11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            auto_sel = 1'b1;
  logic [1:0]      man_mode = 2'b01;
  logic [NREF-1:0] ref_qual = '0;
  logic            ref_switch = 1'b0;
  logic            lock_det = 1'b0;
  logic            hist_valid = 1'b0;
  logic [DW-1:0]   lock_dwell = 4'd3;
  logic [1:0]      mode;
  logic            sync_o, enter_freerun, enter_locking, enter_locked, enter_holdover, mode_chg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpll_mode_ctrl #(.NUM_REFS(NREF), .DWELL_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .auto_sel(auto_sel), .man_mode(man_mode),
    .ref_qual(ref_qual), .ref_switch(ref_switch), .lock_det(lock_det),
    .hist_valid(hist_valid), .lock_dwell(lock_dwell), .mode(mode),
    .sync_o(sync_o), .enter_freerun(enter_freerun), .enter_locking(enter_locking),
    .enter_locked(enter_locked), .enter_holdover(enter_holdover), .mode_chg(mode_chg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // mode plus packed pulses {chg, fr, lkg, lkd, ho} plus sync
  task automatic chk_state(input string req, input logic [1:0] m, input logic [4:0] p);
    chk(req, {30'd0, mode}, {30'd0, m});
    chk({req, "/R9"}, {31'd0, sync_o}, {31'd0, (m == LKD)});
    chk({req, "/R10"}, {27'd0, mode_chg, enter_freerun, enter_locking, enter_locked, enter_holdover},
        {27'd0, p});
  endtask

  task automatic t_reset();
    step();
    chk_state("R1 reset", FR, 5'b00000);
    rst_n = 1'b1;
    step();
    chk_state("R1 idle after reset", FR, 5'b00000);
  endtask

  task automatic t_acquire();
    ref_qual = 3'b100; lock_dwell = 4'd3;
    step();
    chk_state("R2 enter locking", LKG, 5'b10100);
    lock_det = 1'b1;
    step();
    chk_state("R3 dwell 1 of 3", LKG, 5'b00000);
    step();
    chk_state("R3 dwell 2 of 3", LKG, 5'b00000);
    step();
    chk_state("R3 locked after dwell", LKD, 5'b10010);
    step();
    chk_state("R10 no pulse while held", LKD, 5'b00000);
  endtask

  task automatic t_lock_gap();
    lock_det = 1'b0;
    step();
    chk_state("R7 lock loss to locking", LKG, 5'b10100);
    lock_det = 1'b1; step(); step();
    lock_det = 1'b0; step();
    chk_state("R3 gap keeps locking", LKG, 5'b00000);
    lock_det = 1'b1; step(); step();
    chk_state("R3 restarted count", LKG, 5'b00000);
    step();
    chk_state("R3 locked after restart", LKD, 5'b10010);
  endtask

  task automatic t_ref_switch();
    ref_qual = 3'b010;
    ref_switch = 1'b1; step(); ref_switch = 1'b0;
    chk_state("R6 switch while locked", LKG, 5'b10100);
    step(); step();
    ref_switch = 1'b1; step(); ref_switch = 1'b0;
    chk_state("R6 switch while locking", LKG, 5'b00000);
    step(); step();
    chk_state("R6 count restarted", LKG, 5'b00000);
    step();
    chk_state("R6 locked after restart", LKD, 5'b10010);
  endtask

  task automatic t_dwell_zero();
    lock_dwell = 4'd0;
    ref_switch = 1'b1; step(); ref_switch = 1'b0;
    chk_state("R6 back to locking", LKG, 5'b10100);
    step();
    chk_state("R3 zero dwell acts as one", LKD, 5'b10010);
    lock_dwell = 4'd3;
  endtask

  task automatic t_holdover();
    hist_valid = 1'b1; ref_qual = '0;
    step();
    chk_state("R4 no ref with history", HO, 5'b10001);
    hist_valid = 1'b0;
    step(); step();
    chk_state("R11 holdover kept", HO, 5'b00000);
    ref_qual = 3'b001; lock_det = 1'b0;
    step();
    chk_state("R5 ref returns", LKG, 5'b10100);
  endtask

  task automatic t_freerun();
    hist_valid = 1'b0; ref_qual = '0;
    step();
    chk_state("R4 no ref without history", FR, 5'b11000);
    step();
    chk_state("R4 stays freerun", FR, 5'b00000);
  endtask

  task automatic t_manual();
    auto_sel = 1'b0; ref_qual = '0; lock_det = 1'b0; man_mode = 2'b10;
    step();
    chk_state("R8 force locked", LKD, 5'b10010);
    man_mode = 2'b01;
    step();
    chk_state("R8 code 01 holds", LKD, 5'b00000);
    man_mode = 2'b11;
    step();
    chk_state("R8 force holdover", HO, 5'b10001);
    man_mode = 2'b00; ref_qual = 3'b111; lock_det = 1'b1;
    step();
    chk_state("R8 force freerun", FR, 5'b11000);
    step();
    chk_state("R8 refs ignored in manual", FR, 5'b00000);
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_lock_gap();
    t_ref_switch();
    t_dwell_zero();
    t_holdover();
    t_freerun();
    t_manual();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule